// File: doc/BRIEF.md
# SPI Serial Programming Target

This block is the device-side responder for in-system programming over a four-wire serial link. While the host holds the device in programming mode, the block receives fixed four-byte instructions on MOSI. It runs a synchronisation handshake. It then fills a word-wide staging buffer one word at a time and commits the whole buffer to a page of a modelled flash array. It also writes single bytes into a small modelled EEPROM. Reads of either memory return the addressed byte on MISO during the last byte of the read instruction.

SCK and MOSI are sampled into the system clock domain. MOSI is captured on rising SCK, and MISO is updated after falling SCK, most significant bit first. Each write starts a busy interval counted in system clock cycles. While a flash page is busy, reads inside that page return 0xFF, which lets the host poll for completion. While an EEPROM byte is busy, reads of that byte return 0xFF.

Instruction bytes are numbered 1 to 4 in the order they are sent. Byte 1 is the opcode. Bytes 2 and 3 form a 16-bit address, high part first. Byte 4 carries data. The word index within a page is address bits [6:0], and the page number is address bits [15:7].

Top module: `spi_prog_target`

## Requirements
- R1: Every instruction is exactly 32 SCK cycles long. Lowering `prog_mode` discards a partial instruction, so the next rising SCK edge starts byte 1 of a new instruction.
- R2: During byte 3 of any instruction whose byte 1 is 0xAC, MISO returns byte 2 of that instruction. An instruction with byte 1 = 0xAC and byte 2 = 0x53 makes the block synchronised; bytes 3 and 4 are don't-care. Outside the read cases of R7 and R9, MISO sends 0x00.
- R3: MOSI is sampled on rising SCK, MISO changes only after falling SCK, and bytes travel MSB first. MISO is low after reset.
- R4: Until synchronised, every other instruction is ignored: writes have no effect and reads return 0x00. Driving `prog_mode` low returns the block to the unsynchronised state.
- R5: Opcode 0x40 stages byte 4 as a low data byte. Opcode 0x48 writes the buffer word at index addr[6:0] as {byte 4, last staged low byte}.
- R6: Opcode 0x4C copies all 128 buffer words at once into the flash page addr[15:7]. Only the low PAGE_SEL_W bits of the page number are kept.
- R7: Opcode 0x20 returns the low byte, and opcode 0x28 the high byte, of the flash word at {page, index} during byte 4.
- R8: For FLASH_BUSY cycles after a page write, reads of that page return 0xFF. Other pages read normally, and the written data reads back once the interval ends.
- R9: Opcode 0xC0 writes byte 4 to EEPROM address addr[EE_ADDR_W-1:0], replacing the old value outright (the location is not AND-ed with it). Opcode 0xA0 returns the stored byte. For EE_BUSY cycles after a write, a read of that address returns 0xFF.
- R10: While either busy interval runs, opcodes 0x40, 0x48, 0x4C and 0xC0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_mode | input | 1 | High while the device is held for programming; low clears framing and sync |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The bench targets the handshake: a failed enable still echoes its own second byte but leaves the block deaf, and a design that synchronised on the first byte alone would accept the writes that follow. It breaks a frame midway and then re-enables, which exposes a design that keeps its bit count. It polls a page immediately after a commit and reads a different page in the same window. It also issues an EEPROM write during the flash interval, which catches a design that masks the wrong page or lets writes through while busy. It loads a high byte without a fresh low byte, overwrites an EEPROM byte with complementary bits, and aliases the upper page bits, which exposes wrong staging, wrong write merging and wrong address slicing.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 16;
  localparam int WORD_IDX_W = 7;
  localparam int PAGE_NUM_W = ADDR_W - WORD_IDX_W;
  localparam int FRAME_BYTES = 4;
  localparam int BYTE_IDX_W = $clog2(FRAME_BYTES);
  localparam int BIT_CNT_W  = $clog2(BYTE_W);

  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] SYNC_KEY   = 8'h53;
  localparam logic [7:0] OP_LD_LO   = 8'h40;
  localparam logic [7:0] OP_LD_HI   = 8'h48;
  localparam logic [7:0] OP_WR_PAGE = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] POLL_BYTE  = 8'hFF;

  function automatic logic [PAGE_NUM_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WORD_IDX_W];
  endfunction

  function automatic logic [WORD_IDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[WORD_IDX_W-1:0];
  endfunction

  function automatic logic [7:0] byte_of(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/spt_shifter.sv
module spt_shifter
  import spt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_mode,
  input  logic                  sck,
  input  logic                  mosi,
  input  logic [BYTE_W-1:0]     tx_byte,
  output logic                  miso,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [3*BYTE_W-1:0]   hdr,
  output logic                  instr_done,
  output logic [4*BYTE_W-1:0]   instr_word
);
  logic [1:0] sck_s, mosi_s;
  logic       sck_p;
  logic       rise_ev, fall_ev;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [BYTE_W-2:0]    rx_sh, tx_sh;
  logic [BYTE_W-1:0]    rx_full;

  assign rise_ev = sck_s[1] & ~sck_p;
  assign fall_ev = ~sck_s[1] & sck_p;
  assign rx_full = {rx_sh, mosi_s[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      mosi_s <= '0;
      sck_p  <= 1'b0;
    end else begin
      sck_s  <= {sck_s[0], sck};
      mosi_s <= {mosi_s[0], mosi};
      sck_p  <= sck_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      byte_idx   <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      miso       <= 1'b0;
      hdr        <= '0;
      instr_done <= 1'b0;
      instr_word <= '0;
    end else if (!prog_mode) begin
      bit_cnt    <= '0;
      byte_idx   <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      miso       <= 1'b0;
      instr_done <= 1'b0;
    end else begin
      instr_done <= 1'b0;
      if (rise_ev) begin
        rx_sh   <= rx_full[BYTE_W-2:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_CNT_W'(BYTE_W-1)) begin
          byte_idx <= byte_idx + 1'b1;
          case (byte_idx)
            2'd0: hdr[23:16] <= rx_full;
            2'd1: hdr[15:8]  <= rx_full;
            2'd2: hdr[7:0]   <= rx_full;
            default: begin
              instr_done <= 1'b1;
              instr_word <= {hdr, rx_full};
            end
          endcase
        end
      end
      if (fall_ev) begin
        if (bit_cnt == '0) begin
          miso  <= tx_byte[BYTE_W-1];
          tx_sh <= tx_byte[BYTE_W-2:0];
        end else begin
          miso  <= tx_sh[BYTE_W-2];
          tx_sh <= {tx_sh[BYTE_W-3:0], 1'b0};
        end
      end
    end
  end

  // R1: a completed frame leaves the framing counters at the start of the next one
  p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (byte_idx == '0 && bit_cnt == '0));

  // R3: MISO moves only after a falling SCK edge (or a programming-mode drop)
  p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_ev && prog_mode) |=> (!prog_mode || $stable(miso)));
endmodule

// File: rtl/spt_busy_timer.sv
module spt_busy_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(LIMIT);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R10: the decoder never restarts an interval that is still running
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R8: the count stays within the configured interval
  p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
endmodule

// File: rtl/spt_store.sv
module spt_store
  import spt_pkg::*;
#(
  parameter int PAGE_SEL_W = 2,
  parameter int EE_ADDR_W  = 6
) (
  input  logic                  clk,
  input  logic                  buf_we,
  input  logic [WORD_IDX_W-1:0] buf_idx,
  input  logic [15:0]           buf_wdata,
  input  logic                  commit,
  input  logic [PAGE_SEL_W-1:0] commit_page,
  input  logic [PAGE_SEL_W+WORD_IDX_W-1:0] fl_raddr,
  output logic [15:0]           fl_rdata,
  input  logic                  ee_we,
  input  logic [EE_ADDR_W-1:0]  ee_waddr,
  input  logic [7:0]            ee_wdata,
  input  logic [EE_ADDR_W-1:0]  ee_raddr,
  output logic [7:0]            ee_rdata
);
  localparam int PG_WORDS = 1 << WORD_IDX_W;
  localparam int FL_WORDS = PG_WORDS << PAGE_SEL_W;
  localparam int EE_BYTES = 1 << EE_ADDR_W;

  logic [15:0] page_buf [PG_WORDS];
  logic [15:0] flash    [FL_WORDS];
  logic [7:0]  eeprom   [EE_BYTES];

  always_ff @(posedge clk) begin
    if (buf_we) page_buf[buf_idx] <= buf_wdata;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PG_WORDS; i++)
        flash[{commit_page, WORD_IDX_W'(i)}] <= page_buf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (ee_we) eeprom[ee_waddr] <= ee_wdata;
  end

  assign fl_rdata = flash[fl_raddr];
  assign ee_rdata = eeprom[ee_raddr];
endmodule

// File: rtl/spi_prog_target.sv
module spi_prog_target
  import spt_pkg::*;
#(
  parameter int PAGE_SEL_W = 2,
  parameter int EE_ADDR_W  = 6,
  parameter int FLASH_BUSY = 2000,
  parameter int EE_BUSY    = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_mode,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic [3*BYTE_W-1:0]   hdr;
  logic                  instr_done;
  logic [4*BYTE_W-1:0]   iw;
  logic [BYTE_W-1:0]     tx_byte, rd_byte;

  logic synced;
  logic [7:0] lo_stage;
  logic [PAGE_SEL_W-1:0] busy_page;
  logic [EE_ADDR_W-1:0]  ee_busy_addr;
  logic fl_busy, ee_busy;

  // header fields of the frame in flight
  logic [7:0]            h_op;
  logic [ADDR_W-1:0]     h_addr;
  logic [PAGE_NUM_W-1:0] h_page_full;
  logic [PAGE_SEL_W-1:0] h_page;
  logic [15:0]           fl_rword;
  logic [7:0]            ee_rbyte;
  logic                  fl_poll_hit, ee_poll_hit;

  // completed-frame fields
  logic [7:0]            w_op;
  logic [ADDR_W-1:0]     w_addr;
  logic [7:0]            w_data;
  logic [PAGE_NUM_W-1:0] w_page_full;
  logic [PAGE_SEL_W-1:0] w_page;

  // named internal events
  logic en_hit, act, lo_we, buf_we, fl_commit, ee_we;

  spt_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sck(sck), .mosi(mosi),
    .tx_byte(tx_byte), .miso(miso), .byte_idx(byte_idx), .hdr(hdr),
    .instr_done(instr_done), .instr_word(iw)
  );

  assign h_op        = hdr[23:16];
  assign h_addr      = hdr[15:0];
  assign h_page_full = page_of(h_addr);
  assign h_page      = h_page_full[PAGE_SEL_W-1:0];
  assign fl_poll_hit = fl_busy && (h_page == busy_page);
  assign ee_poll_hit = ee_busy && (h_addr[EE_ADDR_W-1:0] == ee_busy_addr);

  always_comb begin
    rd_byte = 8'h00;
    if (h_op == OP_RD_LO || h_op == OP_RD_HI)
      rd_byte = fl_poll_hit ? POLL_BYTE : byte_of(fl_rword, h_op == OP_RD_HI);
    else if (h_op == OP_EE_RD)
      rd_byte = ee_poll_hit ? POLL_BYTE : ee_rbyte;
  end

  always_comb begin
    tx_byte = 8'h00;
    if (byte_idx == 2'd2 && h_op == OP_ENABLE) tx_byte = hdr[15:8];
    else if (byte_idx == 2'd3 && synced)       tx_byte = rd_byte;
  end

  assign w_op        = iw[31:24];
  assign w_addr      = iw[23:8];
  assign w_data      = iw[7:0];
  assign w_page_full = page_of(w_addr);
  assign w_page      = w_page_full[PAGE_SEL_W-1:0];

  assign en_hit    = instr_done && w_op == OP_ENABLE && iw[23:16] == SYNC_KEY;
  assign act       = instr_done && synced && !fl_busy && !ee_busy;
  assign lo_we     = act && w_op == OP_LD_LO;
  assign buf_we    = act && w_op == OP_LD_HI;
  assign fl_commit = act && w_op == OP_WR_PAGE;
  assign ee_we     = act && w_op == OP_EE_WR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced       <= 1'b0;
      lo_stage     <= 8'h00;
      busy_page    <= '0;
      ee_busy_addr <= '0;
    end else begin
      if (!prog_mode)  synced <= 1'b0;
      else if (en_hit) synced <= 1'b1;
      if (lo_we)     lo_stage     <= w_data;
      if (fl_commit) busy_page    <= w_page;
      if (ee_we)     ee_busy_addr <= w_addr[EE_ADDR_W-1:0];
    end
  end

  spt_busy_timer #(.LIMIT(FLASH_BUSY)) u_fl_timer (
    .clk(clk), .rst_n(rst_n), .start(fl_commit), .busy(fl_busy)
  );

  spt_busy_timer #(.LIMIT(EE_BUSY)) u_ee_timer (
    .clk(clk), .rst_n(rst_n), .start(ee_we), .busy(ee_busy)
  );

  spt_store #(.PAGE_SEL_W(PAGE_SEL_W), .EE_ADDR_W(EE_ADDR_W)) u_store (
    .clk(clk),
    .buf_we(buf_we), .buf_idx(word_of(w_addr)), .buf_wdata({w_data, lo_stage}),
    .commit(fl_commit), .commit_page(w_page),
    .fl_raddr({h_page, word_of(h_addr)}), .fl_rdata(fl_rword),
    .ee_we(ee_we), .ee_waddr(w_addr[EE_ADDR_W-1:0]), .ee_wdata(w_data),
    .ee_raddr(h_addr[EE_ADDR_W-1:0]), .ee_rdata(ee_rbyte)
  );

  // R4: leaving programming mode drops synchronisation
  p_unsync_on_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> !synced);

  // R8: a page commit opens the polling window on that page
  p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_commit |=> (fl_busy && busy_page == $past(w_page)));

  // R9: an EEPROM write opens the polling window on that byte
  p_ee_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ee_we |=> ee_busy);

  // R1: one frame yields at most one action
  p_one_action_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_hit, lo_we, buf_we, fl_commit, ee_we}));
endmodule

// File: tb/spi_prog_target_test.sv
module spi_prog_target_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_mode = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_prog_target uut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic instr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] b3, output logic [7:0] r2, output logic [7:0] r3);
    logic [7:0] d;
    xfer(b0, d);
    xfer(b1, d);
    xfer(b2, r2);
    xfer(b3, r3);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_mode();
    prog_mode = 1'b0;
    wait_clk(50);
    prog_mode = 1'b1;
    wait_clk(20);
  endtask

  task automatic t_reset();
    check8("R3 miso low after reset", {7'd0, miso}, 8'h00);
  endtask

  task automatic t_handshake();
    logic [7:0] r2, r3;
    prog_mode = 1'b1;
    wait_clk(20);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R4 read before sync returns zero", r3, 8'h00);
    instr(8'hAC, 8'h00, 8'h00, 8'h00, r2, r3);
    check8("R2 echo of wrong key", r2, 8'h00);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R4 still unsynced after bad key", r3, 8'h00);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    check8("R2 R3 echo of sync key", r2, 8'h53);
  endtask

  task automatic t_eeprom();
    logic [7:0] r2, r3;
    instr(8'hC0, 8'h00, 8'h06, 8'h3C, r2, r3);
    wait_clk(1500);
    instr(8'hC0, 8'h00, 8'h09, 8'h5A, r2, r3);
    wait_clk(1500);
    instr(8'hC0, 8'h00, 8'h05, 8'h0F, r2, r3);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R9 poll busy EEPROM byte", r3, 8'hFF);
    instr(8'hA0, 8'h00, 8'h06, 8'h00, r2, r3);
    check8("R9 other EEPROM byte during busy", r3, 8'h3C);
    wait_clk(1500);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R9 EEPROM read after write", r3, 8'h0F);
    instr(8'hC0, 8'h00, 8'h05, 8'hF0, r2, r3);
    wait_clk(1500);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R9 overwrite replaces old bits", r3, 8'hF0);
  endtask

  task automatic t_unsync();
    logic [7:0] r2, r3;
    pulse_mode();
    instr(8'hC0, 8'h00, 8'h05, 8'h77, r2, r3);
    wait_clk(1500);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R4 read after mode drop returns zero", r3, 8'h00);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    instr(8'hA0, 8'h00, 8'h05, 8'h00, r2, r3);
    check8("R4 unsynced write ignored", r3, 8'hF0);
  endtask

  task automatic t_partial();
    logic [7:0] r2, r3, d;
    xfer(8'h55, d);
    xfer(8'h66, d);
    mosi = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    pulse_mode();
    instr(8'hAC, 8'h53, 8'h00, 8'h00, r2, r3);
    check8("R1 framing restarts after mode drop", r2, 8'h53);
  endtask

  task automatic t_flash();
    logic [7:0] r2, r3;
    instr(8'h40, 8'h00, 8'h00, 8'h34, r2, r3);
    instr(8'h48, 8'h00, 8'h00, 8'h12, r2, r3);
    instr(8'h40, 8'h00, 8'h7F, 8'h78, r2, r3);
    instr(8'h48, 8'h00, 8'h7F, 8'h56, r2, r3);
    instr(8'h4C, 8'h00, 8'h00, 8'h00, r2, r3);
    instr(8'h20, 8'h00, 8'h00, 8'h00, r2, r3);
    check8("R8 poll page 0 while busy", r3, 8'hFF);
    wait_clk(2500);
    instr(8'h20, 8'h00, 8'h00, 8'h00, r2, r3);
    check8("R6 R7 page 0 word 0 low", r3, 8'h34);
    instr(8'h28, 8'h00, 8'h00, 8'h00, r2, r3);
    check8("R7 page 0 word 0 high", r3, 8'h12);
    instr(8'h28, 8'h00, 8'h7F, 8'h00, r2, r3);
    check8("R6 page 0 last word high", r3, 8'h56);

    instr(8'h40, 8'h00, 8'h83, 8'hAA, r2, r3);
    instr(8'h48, 8'h00, 8'h83, 8'hBB, r2, r3);
    instr(8'h48, 8'h00, 8'h84, 8'hCC, r2, r3);
    instr(8'h4C, 8'h00, 8'h80, 8'h00, r2, r3);
    instr(8'h20, 8'h00, 8'h83, 8'h00, r2, r3);
    check8("R8 poll page 1 while busy", r3, 8'hFF);
    instr(8'h20, 8'h00, 8'h00, 8'h00, r2, r3);
    check8("R8 other page readable while busy", r3, 8'h34);
    instr(8'hC0, 8'h00, 8'h09, 8'h99, r2, r3);
    wait_clk(2500);
    instr(8'h20, 8'h00, 8'h83, 8'h00, r2, r3);
    check8("R5 low byte of page 1 word 3", r3, 8'hAA);
    instr(8'h28, 8'h00, 8'h83, 8'h00, r2, r3);
    check8("R5 high byte of page 1 word 3", r3, 8'hBB);
    instr(8'h28, 8'h00, 8'h84, 8'h00, r2, r3);
    check8("R5 high-only load high byte", r3, 8'hCC);
    instr(8'h20, 8'h00, 8'h84, 8'h00, r2, r3);
    check8("R5 high-only load reuses staged low", r3, 8'hAA);
    instr(8'h28, 8'h02, 8'h83, 8'h00, r2, r3);
    check8("R6 upper page bits dropped", r3, 8'hBB);
    instr(8'hA0, 8'h00, 8'h09, 8'h00, r2, r3);
    check8("R10 EEPROM write during flash busy ignored", r3, 8'h5A);
    instr(8'h40, 8'h00, 8'h00, 8'h11, r2, r3);
    check8("R2 non-enable echo is zero", r2, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_handshake();
    t_eeprom();
    t_unsync();
    t_partial();
    t_flash();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule